// File: doc/BRIEF.md
# Banked Debug Probe Output Multiplexer

This block exposes a chosen group of internal signals on a fixed 16-bit debug port, so that an external sampling instrument can watch them. Probes come in as one flat vector made of banks of 16 lanes. Bank `b` occupies bits `[16*b+15 : 16*b]`. The number of banks is set at build time, from 1 to 64.

The bank index is loaded over a slow serial control port with its own clock. The index crosses into the design clock domain through a toggle handshake. The multiplexer select is only ever loaded as a whole word, on a design-clock edge, so a partly changed select value is never used.

A build-time switch picks one of two output styles:
- **Registered style:** the selected bank passes through four design-clock registers. A forwarded clock goes out beside the data and rises mid-cycle, so it lands in the centre of each data word.
- **Combinational style:** the selected bank drives the port directly, and the forwarded clock stays low.

Top module: `probe_bank_mux`

## Requirements
- R1: While `rst` is high, and after it, the registered style drives `dbg_data` to 0 and holds the bank select at 0 until a bank is loaded. Because the pipeline is cleared by reset, the first three design edges after reset still leave `dbg_data` at 0.
- R2: In the registered style, `dbg_data` sampled after design edge `j` equals the selected bank's probe value that was captured at edge `j-3`. Put another way, the value presented before edge `j-3` reaches the port four registers later.
- R3: The control port shifts `ctl_din` into a 6-bit register on each `ctl_clk` edge where `ctl_shift` is 1, least significant bit first. An edge where `ctl_update` is 1 and `ctl_shift` is 0 copies that register into the holding register. After the domain crossing, the design then switches to that bank.
- R4: A loaded index greater than or equal to `BANKS` selects bank 0.
- R5: Shifting without an update strobe leaves the selected bank unchanged.
- R6: If `ctl_shift` and `ctl_update` are both 1 on the same control edge, the shift takes place and the update is dropped. A later update on its own then loads the shifted value.
- R7: In the registered style, `dbg_clk` stays low during reset and for the first four design edges after it. From then on it is the inverse of `clk`: low while `clk` is high and high while `clk` is low.
- R8: In the combinational style, `dbg_data` equals the selected bank's current probe value with no register in the path, and `dbg_clk` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst | input | 1 | Synchronous active-high reset, design domain |
| ctl_clk | input | 1 | Slow serial control clock |
| ctl_rst | input | 1 | Synchronous active-high reset, control domain |
| ctl_din | input | 1 | Serial index data, least significant bit first |
| ctl_shift | input | 1 | Shift enable for the index register |
| ctl_update | input | 1 | Strobe that copies the index register into the holding register |
| probe_in | input | 16*BANKS | Flat probe vector; bank b is bits 16*b+15 to 16*b |
| dbg_data | output | 16 | Debug port data |
| dbg_clk | output | 1 | Forwarded clock; low in the combinational style |

## Verification
Two control actions can fall on the same control-clock edge: a shift and an update strobe. The bench provokes this by raising the update strobe on the edge that carries the last shifted bit. It then judges the result from the data port: the old bank must still be visible, and a following update on its own must bring in the new bank. The bench also sweeps all 64 index values against a 4-bank build, in both output styles. During each sweep the probe data changes on every design cycle, so the four-cycle latency and the wrap of out-of-range indices to bank 0 are checked on moving data.

// File: rtl/probe_pkg.sv
package probe_pkg;
    localparam int LANES      = 16;
    localparam int SEL_W      = 6;
    localparam int MAX_BANKS  = 1 << SEL_W;
    localparam int PIPE_DEPTH = 4;

    typedef logic [LANES-1:0] lane_word_t;
    typedef logic [SEL_W-1:0] bank_idx_t;

    // Holding register and its toggle flag, as seen across the domain crossing.
    typedef struct packed {
        logic      tog;
        bank_idx_t idx;
    } sel_msg_t;

    function automatic bank_idx_t clamp_bank(bank_idx_t raw, int unsigned banks);
        return (int'(raw) < int'(banks)) ? raw : '0;
    endfunction
endpackage

// File: rtl/ctl_shifter.sv
module ctl_shifter
    import probe_pkg::*;
(
    input  logic     ctl_clk,
    input  logic     ctl_rst,
    input  logic     din,
    input  logic     shift_en,
    input  logic     update,
    output sel_msg_t msg_o
);
    bank_idx_t sr_q;
    sel_msg_t  msg_q;

    always_ff @(posedge ctl_clk) begin
        if (ctl_rst) begin
            sr_q  <= '0;
            msg_q <= '0;
        end else if (shift_en) begin
            // Shifting takes priority over the update strobe.
            sr_q <= {din, sr_q[SEL_W-1:1]};
        end else if (update) begin
            msg_q.idx <= sr_q;
            msg_q.tog <= ~msg_q.tog;
        end
    end

    assign msg_o = msg_q;
endmodule

// File: rtl/sel_sync.sv
module sel_sync
    import probe_pkg::*;
#(
    parameter int BANKS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  sel_msg_t  msg_i,
    output bank_idx_t sel_o,
    output logic      upd_o
);
    logic [2:0] tog_sync_q;
    bank_idx_t  sel_q;

    always_ff @(posedge clk) begin
        if (rst) tog_sync_q <= '0;
        else     tog_sync_q <= {tog_sync_q[1:0], msg_i.tog};
    end

    // A change of the synchronised toggle marks a new, already settled index.
    assign upd_o = tog_sync_q[2] ^ tog_sync_q[1];

    always_ff @(posedge clk) begin
        if (rst)        sel_q <= '0;
        else if (upd_o) sel_q <= clamp_bank(msg_i.idx, BANKS);
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/probe_path.sv
module probe_path
    import probe_pkg::*;
#(
    parameter int BANKS      = 4,
    parameter bit STATE_MODE = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [BANKS*LANES-1:0] probe_i,
    input  bank_idx_t              sel_i,
    output lane_word_t             word_o,
    output lane_word_t             dbg_data_o,
    output logic                   dbg_clk_o
);
    lane_word_t bank_w [BANKS];
    lane_word_t word;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign bank_w[b] = probe_i[b*LANES +: LANES];
    end

    always_comb begin
        word = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (sel_i == bank_idx_t'(b)) word = bank_w[b];
        end
    end
    assign word_o = word;

    if (STATE_MODE) begin : g_state
        lane_word_t            stg_q [PIPE_DEPTH];
        logic [PIPE_DEPTH-1:0] fwd_en_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < PIPE_DEPTH; i++) stg_q[i] <= '0;
                fwd_en_q <= '0;
            end else begin
                stg_q[0] <= word;
                for (int i = 1; i < PIPE_DEPTH; i++) stg_q[i] <= stg_q[i-1];
                fwd_en_q <= {fwd_en_q[PIPE_DEPTH-2:0], 1'b1};
            end
        end

        assign dbg_data_o = stg_q[PIPE_DEPTH-1];
        // The forwarded clock rises mid-cycle, in the centre of each data word.
        assign dbg_clk_o  = ~clk & fwd_en_q[PIPE_DEPTH-1];
    end else begin : g_timing
        assign dbg_data_o = word;
        assign dbg_clk_o  = 1'b0;
    end
endmodule

// File: rtl/probe_bank_mux.sv
module probe_bank_mux
    import probe_pkg::*;
#(
    parameter int BANKS      = 4,
    parameter bit STATE_MODE = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctl_clk,
    input  logic                   ctl_rst,
    input  logic                   ctl_din,
    input  logic                   ctl_shift,
    input  logic                   ctl_update,
    input  logic [BANKS*LANES-1:0] probe_in,
    output logic [LANES-1:0]       dbg_data,
    output logic                   dbg_clk
);
    if (BANKS < 1 || BANKS > MAX_BANKS) begin : g_bad_cfg
        $error("BANKS out of range");
    end

    sel_msg_t   ctl_msg;
    bank_idx_t  sel_q;
    logic       upd_pulse;
    lane_word_t bank_word;

    ctl_shifter u_ctl (
        .ctl_clk  (ctl_clk),
        .ctl_rst  (ctl_rst),
        .din      (ctl_din),
        .shift_en (ctl_shift),
        .update   (ctl_update),
        .msg_o    (ctl_msg)
    );

    sel_sync #(.BANKS(BANKS)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .msg_i (ctl_msg),
        .sel_o (sel_q),
        .upd_o (upd_pulse)
    );

    probe_path #(.BANKS(BANKS), .STATE_MODE(STATE_MODE)) u_path (
        .clk        (clk),
        .rst        (rst),
        .probe_i    (probe_in),
        .sel_i      (sel_q),
        .word_o     (bank_word),
        .dbg_data_o (dbg_data),
        .dbg_clk_o  (dbg_clk)
    );
endmodule

// File: rtl/probe_bank_mux_chk.sv
module probe_bank_mux_chk
    import probe_pkg::*;
#(
    parameter int BANKS      = 4,
    parameter bit STATE_MODE = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       ctl_clk,
    input logic       ctl_rst,
    input logic       ctl_shift,
    input lane_word_t dbg_data,
    input logic       dbg_clk,
    input bank_idx_t  sel_q,
    input logic       upd_pulse,
    input sel_msg_t   hold_msg,
    input lane_word_t bank_word
);
    logic [2:0] since_rst_q;

    always_ff @(posedge clk) begin
        if (rst)                    since_rst_q <= '0;
        else if (since_rst_q != 3'd7) since_rst_q <= since_rst_q + 3'd1;
    end

    // R4
    sel_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(sel_q) < BANKS);

    // R5
    sel_only_on_update_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_pulse |=> $stable(sel_q));

    // R6
    shift_blocks_update_chk: assert property (@(posedge ctl_clk) disable iff (ctl_rst)
        ctl_shift |=> $stable(hold_msg));

    if (STATE_MODE) begin : g_state_chk
        // R1
        reset_clears_port_chk: assert property (@(posedge clk)
            rst |=> (dbg_data == '0 && sel_q == '0));

        // R2
        four_stage_latency_chk: assert property (@(posedge clk) disable iff (rst)
            (since_rst_q >= 3'd4) |-> dbg_data == $past(bank_word, 4));

        // R7
        fwd_clk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (since_rst_q < 3'd4) |-> !dbg_clk);
    end
endmodule

bind probe_bank_mux probe_bank_mux_chk #(.BANKS(BANKS), .STATE_MODE(STATE_MODE)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ctl_clk   (ctl_clk),
    .ctl_rst   (ctl_rst),
    .ctl_shift (ctl_shift),
    .dbg_data  (dbg_data),
    .dbg_clk   (dbg_clk),
    .sel_q     (sel_q),
    .upd_pulse (upd_pulse),
    .hold_msg  (ctl_msg),
    .bank_word (bank_word)
);

// File: tb/probe_bank_mux_test.sv
`timescale 1ns/1ps
module probe_bank_mux_test;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_clk = 1'b0;
    logic          ctl_rst = 1'b1;
    logic          ctl_din = 1'b0;
    logic          ctl_shift = 1'b0;
    logic          ctl_update = 1'b0;
    logic [NB*16-1:0] probe_in = '0;
    logic [15:0]   dbg_data, dbg_data_t;
    logic          dbg_clk, dbg_clk_t;

    int checks = 0;
    int fails  = 0;
    int gi     = 0;

    always #2  clk = ~clk;
    always #20 ctl_clk = ~ctl_clk;

    probe_bank_mux #(.BANKS(NB), .STATE_MODE(1'b1)) uut (
        .clk(clk), .rst(rst), .ctl_clk(ctl_clk), .ctl_rst(ctl_rst),
        .ctl_din(ctl_din), .ctl_shift(ctl_shift), .ctl_update(ctl_update),
        .probe_in(probe_in), .dbg_data(dbg_data), .dbg_clk(dbg_clk));

    probe_bank_mux #(.BANKS(NB), .STATE_MODE(1'b0)) uut_t (
        .clk(clk), .rst(rst), .ctl_clk(ctl_clk), .ctl_rst(ctl_rst),
        .ctl_din(ctl_din), .ctl_shift(ctl_shift), .ctl_update(ctl_update),
        .probe_in(probe_in), .dbg_data(dbg_data_t), .dbg_clk(dbg_clk_t));

    function automatic logic [15:0] word_of(int i, int b);
        return 16'((i * 37 + b * 5 + 1) ^ (b << 12));
    endfunction

    function automatic logic [NB*16-1:0] probes_of(int i);
        logic [NB*16-1:0] v;
        for (int b = 0; b < NB; b++) v[b*16 +: 16] = word_of(i, b);
        return v;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Shift six index bits, LSB first; optionally raise update with the last bit.
    task automatic shift_idx(input int v, input bit collide);
        for (int k = 0; k < 6; k++) begin
            @(negedge ctl_clk);
            ctl_shift  = 1'b1;
            ctl_din    = v[k];
            ctl_update = collide && (k == 5);
        end
        @(negedge ctl_clk);
        ctl_shift  = 1'b0;
        ctl_update = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge ctl_clk);
        ctl_update = 1'b1;
        @(negedge ctl_clk);
        ctl_update = 1'b0;
        repeat (20) @(posedge clk);
    endtask

    task automatic load_idx(input int v);
        shift_idx(v, 1'b0);
        pulse_update();
    endtask

    // Stream moving probe data; check both styles against the expected bank.
    task automatic stream(input int exp_bank, input string req, input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            if (k >= 4) chk({req, " R2 state"}, dbg_data, word_of(gi - 4, exp_bank));
            probe_in = probes_of(gi);
            #0.5;
            chk({req, " R8 timing"}, dbg_data_t, word_of(gi, exp_bank));
            chk("R8 timing clk low", {15'd0, dbg_clk_t}, 16'd0);
            gi++;
        end
    endtask

    initial begin
        #600000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        probe_in = probes_of(999);
        repeat (3) @(posedge ctl_clk);
        repeat (2) begin
            @(posedge clk);
            #1;
            chk("R1 reset data", dbg_data, 16'd0);
            chk("R7 reset clk high phase", {15'd0, dbg_clk}, 16'd0);
            @(negedge clk);
            #1;
            chk("R7 reset clk low phase", {15'd0, dbg_clk}, 16'd0);
        end
        @(negedge ctl_clk);
        ctl_rst = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // Edges 1..8 after release: data zero for three edges, then bank 0 probes.
        for (int e = 1; e <= 8; e++) begin
            @(posedge clk);
            #1;
            if (e <= 3) chk("R1 pipeline cleared", dbg_data, 16'd0);
            else        chk("R1 default bank 0", dbg_data, word_of(999, 0));
            chk("R7 high phase low", {15'd0, dbg_clk}, 16'd0);
            @(negedge clk);
            #1;
            chk("R7 low phase", {15'd0, dbg_clk}, (e >= 4) ? 16'd1 : 16'd0);
        end

        // Exhaustive index sweep: R3 load path, R4 wrap of out-of-range values.
        for (int v = 0; v < 64; v++) begin
            load_idx(v);
            stream((v < NB) ? v : 0, (v < NB) ? "R3 load" : "R4 wrap", 10);
        end

        // R5: shifting a new value without update keeps bank 2.
        load_idx(2);
        stream(2, "R3 load", 8);
        shift_idx(3, 1'b0);
        repeat (20) @(posedge clk);
        stream(2, "R5 shift only", 8);

        // R6: update on the same edge as the last shift bit is dropped.
        shift_idx(1, 1'b1);
        repeat (20) @(posedge clk);
        stream(2, "R6 collision", 8);
        pulse_update();
        stream(1, "R6 later update", 8);

        // R7: forwarded clock during steady operation.
        for (int e = 0; e < 4; e++) begin
            @(posedge clk);
            #1;
            chk("R7 steady high phase", {15'd0, dbg_clk}, 16'd0);
            @(negedge clk);
            #1;
            chk("R7 steady low phase", {15'd0, dbg_clk}, 16'd1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule